// File: doc/BRIEF.md
# Processor Power State Controller

This controller tracks the low-power state of a core that runs two hardware threads. It has four states: Normal, HALT, Stop Grant and Grant Snoop. The core enters HALT only when every thread reports halted. Any interrupt or break line returns it to Normal.

A stop-clock request, raised in Normal or HALT, starts a handshake. The controller asks for the stop-grant acknowledge bus cycle and waits for that cycle's response-phase strobe. It then counts a fixed number of clocks before entering Stop Grant. If the request is withdrawn during the handshake, the sequence aborts and the counter is cleared.

While in Stop Grant, the controller behaves as follows:
- A detected snoop moves it to Grant Snoop until the snoop completes.
- A BINIT is latched as pending instead of being serviced.
- A core reset reinitializes the core without leaving Stop Grant.
- Removing the stop-clock request returns it to the state it came from.

Clock gating, voltage control and the bus protocol are outside this block. The acknowledge cycle and its response phase appear only as strobes.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After `rst_ni` is released, `state_o` is Normal, and `ack_req_o`, `binit_pend_o` and `init_o` are 0. The state is one-hot: Normal = 4'b0001, HALT = 4'b0010, Stop Grant = 4'b0100, Grant Snoop = 4'b1000.
- R2: In Normal, HALT is entered at the next clock edge only when every bit of `halt_i` is 1 and no break line is active. With only some bits set, the state stays Normal.
- R3: In HALT, any of `smi_i`, `binit_i`, `init_i`, `lint_i[0]` or `lint_i[1]` returns the state to Normal at the next edge. A BINIT in HALT does not set the pending flag.
- R4: When `stopclk_i` is sampled high in Normal or HALT with no sequence running, `ack_req_o` rises at the next edge. It stays high until `ack_resp_i` is sampled high.
- R5: Stop Grant is entered exactly SG_DELAY clock edges (default 20) after the edge at which `ack_resp_i` is sampled high.
- R6: If `stopclk_i` goes low while the acknowledge is requested or the count is running, the sequence aborts. `ack_req_o` falls, the state remains Normal or HALT, and a later request counts the full SG_DELAY again.
- R7: In Stop Grant, `stopclk_i` low returns the state at the next edge to HALT if the sequence began in HALT, and to Normal otherwise.
- R8: `snoop_i` in Stop Grant moves the state to Grant Snoop at the next edge. `snoop_done_i` in Grant Snoop moves it back to Stop Grant at the next edge.
- R9: `binit_i` in Stop Grant or Grant Snoop sets `binit_pend_o` at the next edge and does not change the state. `binit_clr_i` is ignored in those two states and clears the flag in Normal or HALT.
- R10: `core_rst_i` raises `init_o` for the following cycle. In Normal or HALT it also:
  - forces Normal;
  - cancels any stop-grant sequence;
  - clears `binit_pend_o`.
  In Stop Grant the state and the pending flag are kept.
- R11: `snoop_en_o` is 1 in Normal, HALT and Grant Snoop, and 0 in Stop Grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_rst_i | input | 1 | Synchronous core reset request |
| halt_i | input | THREADS | Per-thread halted indication |
| smi_i | input | 1 | System management interrupt |
| binit_i | input | 1 | Bus initialization break |
| init_i | input | 1 | Init break |
| lint_i | input | 2 | Local interrupt pins |
| stopclk_i | input | 1 | Stop-clock request |
| snoop_i | input | 1 | Snoop detected strobe |
| snoop_done_i | input | 1 | Snoop finished strobe |
| ack_resp_i | input | 1 | Response phase of the acknowledge cycle |
| binit_clr_i | input | 1 | Software clear of pending BINIT |
| state_o | output | 4 | One-hot power state |
| ack_req_o | output | 1 | Request to issue the stop-grant acknowledge cycle |
| binit_pend_o | output | 1 | BINIT latched while stopped |
| snoop_en_o | output | 1 | Snoop servicing enabled |
| init_o | output | 1 | Initialization pulse |

## Verification
The halt inputs are tried in two patterns:
- only one thread halted, which shows that entry needs every thread;
- both threads halted, which shows that HALT is entered.

Each of the five break lines is applied alone from HALT, so a missing term in the break OR is caught. The stop-grant count is checked one edge before and at the expected edge, both after a clean start and after an abort in mid-count; this separates an exact delay from an off-by-one error or a counter that was not cleared. Entering Stop Grant from Normal and from HALT shows whether the exit returns to the right state. Issuing reset and BINIT clear inside and outside Stop Grant shows that both are gated by state.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
  typedef enum logic [3:0] {
    ST_RUN  = 4'b0001,
    ST_HALT = 4'b0010,
    ST_SGNT = 4'b0100,
    ST_SNP  = 4'b1000
  } pstate_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_CNT  = 2'd2
  } seq_e;
endpackage

// File: rtl/psc_seq.sv
`timescale 1ns/1ps
module psc_seq
  import psc_pkg::*;
#(
  parameter int unsigned DELAY = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic go_i,
  input  logic resp_i,
  output logic ack_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

  seq_e          seq_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SQ_IDLE;
      cnt_q <= '0;
    end else if (flush_i || !go_i) begin
      seq_q <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (seq_q)
        SQ_IDLE: seq_q <= SQ_REQ;
        SQ_REQ: if (resp_i) begin
          seq_q <= SQ_CNT;
          cnt_q <= LOAD;
        end
        SQ_CNT: if (cnt_q == '0) seq_q <= SQ_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: seq_q <= SQ_IDLE;
      endcase
    end
  end

  assign ack_o  = (seq_q == SQ_REQ);
  assign done_o = (seq_q == SQ_CNT) && (cnt_q == '0) && go_i && !flush_i;

  AST_CNT_ONLY_COUNTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_q != SQ_CNT) |-> (cnt_q == '0)); // R6
  AST_ABORT_DROPS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> !ack_o); // R6
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !resp_i && go_i && !flush_i) |=> ack_o); // R4
endmodule

// File: rtl/psc_binit.sv
`timescale 1ns/1ps
module psc_binit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_sg_i,
  input  logic binit_i,
  input  logic clr_i,
  input  logic flush_i,
  output logic pend_o
);
  logic pend_q;
  logic set_w, drop_w;

  assign set_w  = binit_i & in_sg_i;
  assign drop_w = (clr_i | flush_i) & ~in_sg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_w)  pend_q <= 1'b1;
    else if (drop_w) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_BINIT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sg_i && binit_i) |=> pend_o); // R9
  AST_CLR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sg_i && pend_o) |=> pend_o); // R9
endmodule

// File: rtl/psc_fsm.sv
`timescale 1ns/1ps
module psc_fsm
  import psc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    core_rst_i,
  input  logic    all_halt_i,
  input  logic    brk_i,
  input  logic    stopclk_i,
  input  logic    seq_done_i,
  input  logic    snoop_i,
  input  logic    snoop_done_i,
  output pstate_e state_o
);
  pstate_e state_q, state_d;
  logic    ret_halt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (core_rst_i)                 state_d = ST_RUN;
        else if (seq_done_i)            state_d = ST_SGNT;
        else if (all_halt_i && !brk_i)  state_d = ST_HALT;
      end
      ST_HALT: begin
        if (core_rst_i)      state_d = ST_RUN;
        else if (seq_done_i) state_d = ST_SGNT;
        else if (brk_i)      state_d = ST_RUN;
      end
      ST_SGNT: begin
        if (!stopclk_i)   state_d = ret_halt_q ? ST_HALT : ST_RUN;
        else if (snoop_i) state_d = ST_SNP;
      end
      ST_SNP: if (snoop_done_i) state_d = ST_SGNT;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      ret_halt_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (seq_done_i && (state_q == ST_RUN || state_q == ST_HALT))
        ret_halt_q <= (state_q == ST_HALT);
    end
  end

  assign state_o = state_q;

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1); // R1
  AST_HALT_NEEDS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !all_halt_i) |=> (state_q != ST_HALT)); // R2
  AST_HALT_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && brk_i && !seq_done_i) |=> (state_q == ST_RUN)); // R3
  AST_SG_KEEPS_ON_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SGNT && core_rst_i && stopclk_i && !snoop_i) |=> (state_q == ST_SGNT)); // R10
  AST_SNOOP_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SNP && snoop_done_i) |=> (state_q == ST_SGNT)); // R8
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
module pwr_state_ctrl
  import psc_pkg::*;
#(
  parameter int unsigned THREADS  = 2,
  parameter int unsigned SG_DELAY = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               core_rst_i,
  input  logic [THREADS-1:0] halt_i,
  input  logic               smi_i,
  input  logic               binit_i,
  input  logic               init_i,
  input  logic [1:0]         lint_i,
  input  logic               stopclk_i,
  input  logic               snoop_i,
  input  logic               snoop_done_i,
  input  logic               ack_resp_i,
  input  logic               binit_clr_i,
  output logic [3:0]         state_o,
  output logic               ack_req_o,
  output logic               binit_pend_o,
  output logic               snoop_en_o,
  output logic               init_o
);
  pstate_e state_w;
  logic    run_w, in_sg_w, brk_w, done_w, init_q;

  assign run_w   = (state_w == ST_RUN) || (state_w == ST_HALT);
  assign in_sg_w = (state_w == ST_SGNT) || (state_w == ST_SNP);
  assign brk_w   = smi_i | binit_i | init_i | (|lint_i);

  psc_seq #(.DELAY(SG_DELAY)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (core_rst_i & run_w),
    .go_i    (stopclk_i & run_w),
    .resp_i  (ack_resp_i),
    .ack_o   (ack_req_o),
    .done_o  (done_w)
  );

  psc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .core_rst_i   (core_rst_i),
    .all_halt_i   (&halt_i),
    .brk_i        (brk_w),
    .stopclk_i    (stopclk_i),
    .seq_done_i   (done_w),
    .snoop_i      (snoop_i),
    .snoop_done_i (snoop_done_i),
    .state_o      (state_w)
  );

  psc_binit u_binit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_sg_i (in_sg_w),
    .binit_i (binit_i),
    .clr_i   (binit_clr_i),
    .flush_i (core_rst_i),
    .pend_o  (binit_pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b0;
    else         init_q <= core_rst_i;
  end

  assign state_o    = state_w;
  assign init_o     = init_q;
  assign snoop_en_o = (state_w != ST_SGNT);

  AST_INIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_i |=> init_o); // R10
  AST_RESET_CANCELS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_i && run_w) |=> !ack_req_o); // R10
endmodule

// File: tb/tb_pwr_state_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_state_ctrl;
  localparam int DLY = 20;
  localparam logic [3:0] S_RUN = 4'b0001, S_HALT = 4'b0010,
                         S_SG = 4'b0100, S_SNP = 4'b1000;

  logic clk = 0, rst_ni = 0;
  logic core_rst = 0, smi = 0, binit = 0, init = 0, stopclk = 0;
  logic snoop = 0, snoop_done = 0, resp = 0, clr = 0;
  logic [1:0] halt = 0, lint = 0;
  logic [3:0] state;
  logic ack, pend, snp_en, init_p;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.THREADS(2), .SG_DELAY(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .core_rst_i(core_rst), .halt_i(halt),
    .smi_i(smi), .binit_i(binit), .init_i(init), .lint_i(lint),
    .stopclk_i(stopclk), .snoop_i(snoop), .snoop_done_i(snoop_done),
    .ack_resp_i(resp), .binit_clr_i(clr), .state_o(state),
    .ack_req_o(ack), .binit_pend_o(pend), .snoop_en_o(snp_en), .init_o(init_p)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // request, respond, count; leaves the state in Stop Grant
  task automatic enter_sg(string tag);
    stopclk = 1; step();
    chk({tag, " ack raised"}, ack, 1);
    resp = 1; step(); resp = 0;
    chk({tag, " ack dropped"}, ack, 0);
    step(DLY - 1);
    chk({tag, " not yet stop grant"}, state != S_SG, 1);
    step();
    chk({tag, " stop grant on time"}, state, S_SG);
  endtask

  task automatic t_reset();
    chk("R1 state", state, S_RUN);
    chk("R1 ack", ack, 0);
    chk("R1 pend", pend, 0);
    chk("R1 init", init_p, 0);
    chk("R11 snoop_en normal", snp_en, 1);
  endtask

  task automatic t_halt();
    halt = 2'b01; step();
    chk("R2 one thread halted", state, S_RUN);
    halt = 2'b10; step();
    chk("R2 other thread halted", state, S_RUN);
    halt = 2'b11; step();
    chk("R2 all halted", state, S_HALT);
    chk("R11 snoop_en halt", snp_en, 1);
  endtask

  task automatic t_breaks();
    for (int i = 0; i < 5; i++) begin
      halt = 2'b11; step();
      chk("R3 in halt", state, S_HALT);
      halt = 2'b00;
      case (i)
        0: smi = 1;
        1: binit = 1;
        2: init = 1;
        3: lint = 2'b01;
        default: lint = 2'b10;
      endcase
      step();
      chk($sformatf("R3 break line %0d", i), state, S_RUN);
      chk("R3 no pend from halt binit", pend, 0);
      smi = 0; binit = 0; init = 0; lint = 0;
    end
  endtask

  task automatic t_sg_normal();
    stopclk = 1; step();
    step(3);
    chk("R4 ack held without response", ack, 1);
    stopclk = 0; step();
    enter_sg("R5 from normal");
    chk("R11 snoop_en stop grant", snp_en, 0);
    snoop = 1; step(); snoop = 0;
    chk("R8 snoop to grant snoop", state, S_SNP);
    chk("R11 snoop_en grant snoop", snp_en, 1);
    step(2);
    chk("R8 waits for done", state, S_SNP);
    snoop_done = 1; step(); snoop_done = 0;
    chk("R8 back to stop grant", state, S_SG);
    binit = 1; step(); binit = 0;
    chk("R9 binit latched", pend, 1);
    chk("R9 state kept", state, S_SG);
    clr = 1; step(); clr = 0;
    chk("R9 clear ignored in stop grant", pend, 1);
    core_rst = 1; step(); core_rst = 0;
    chk("R10 stop grant kept on reset", state, S_SG);
    chk("R10 init pulse", init_p, 1);
    chk("R10 pend kept", pend, 1);
    step();
    chk("R10 init one cycle", init_p, 0);
    stopclk = 0; step();
    chk("R7 exit to normal", state, S_RUN);
    clr = 1; step(); clr = 0;
    chk("R9 clear honoured", pend, 0);
  endtask

  task automatic t_abort();
    stopclk = 1; step();
    resp = 1; step(); resp = 0;
    step(10);
    stopclk = 0; step();
    chk("R6 abort state", state, S_RUN);
    chk("R6 abort ack", ack, 0);
    step(15);
    chk("R6 no late entry", state, S_RUN);
    stopclk = 1; step();
    stopclk = 0; step();
    chk("R6 abort during request", ack, 0);
    enter_sg("R6 full recount");
    stopclk = 0; step();
  endtask

  task automatic t_sg_halt();
    halt = 2'b11; step();
    chk("R7 in halt", state, S_HALT);
    enter_sg("R5 from halt");
    stopclk = 0; step();
    chk("R7 exit to halt", state, S_HALT);
    halt = 0; smi = 1; step(); smi = 0;
    chk("R3 leave halt", state, S_RUN);
  endtask

  task automatic t_core_reset();
    halt = 2'b11; step();
    chk("R10 pre halt", state, S_HALT);
    halt = 0; core_rst = 1; step(); core_rst = 0;
    chk("R10 halt to normal", state, S_RUN);
    chk("R10 init from halt", init_p, 1);
    stopclk = 1; step();
    chk("R10 ack before reset", ack, 1);
    core_rst = 1; step(); core_rst = 0;
    chk("R10 reset cancels ack", ack, 0);
    stopclk = 0; step();
  endtask

  initial begin
    step(3);
    rst_ni = 1;
    step();
    t_reset();
    t_halt();
    t_breaks();
    t_sg_normal();
    t_abort();
    t_sg_halt();
    t_core_reset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule